// File: doc/BRIEF.md
# Chunk Hamming ECC generator

This block sits beside the byte path of a NAND flash controller and computes a single-error-correcting Hamming code over each fixed-size chunk of data that passes through it. Every accepted byte updates a set of running line parities, one pair per address bit of the byte within the chunk. It also updates a set of column parities, one pair per group of bit positions within a byte. When the last byte of a chunk is accepted, the finished code is latched into a code register, a one-cycle valid pulse is raised, and a fresh accumulation begins with no action from software.

The latched code is also given in its spare-area form: three bytes ready to be stored next to the page data. A read or a write can use the same block. The direction flag that is present when a chunk completes is stored with the code, so that the consumer can tell a freshly written code from a recomputed one. A clear strobe drops any partial chunk and empties the code register. Bytes are counted and folded in only while the enable input is high.

Top module: `nand_chunk_ecc_gen`

## Requirements
- R1: After reset, `code_raw` is 0, `code_valid` is 0, `code_from_read` is 0 and `spare_bytes` is 0xFFFFFF.
- R2: A byte is accepted on a clock edge where `ecc_en` and `byte_valid` are high and `ecc_clr` is low. The edge that accepts the 256th byte of a chunk latches the code. `code_valid` is high for exactly the one cycle after that edge.
- R3: Line parity: for each byte-address bit k (0..7) within the chunk, `code_raw[9+2k]` is the XOR of every data bit of the bytes whose address has bit k set. `code_raw[8+2k]` is the XOR of every data bit of the bytes whose address has bit k clear.
- R4: Column parity: for each group i (0..2), `code_raw[3+2i]` is the XOR, over all bytes of the chunk, of the data bits whose bit position has bit i set. `code_raw[2+2i]` covers the bit positions with bit i clear. Every even/odd pair therefore XORs to the overall parity of the chunk.
- R5: `code_raw[1:0]` is always 0.
- R6: `spare_bytes` equals the bitwise inverse of `code_raw` shifted left by 2, kept to 24 bits. The first spare byte is `spare_bytes[23:16]`, the second is `[15:8]` and the third is `[7:0]`.
- R7: An `ecc_clr` pulse empties the partial accumulation, restarts the byte count and sets `code_raw` to 0 in the next cycle. A byte offered in the same cycle as the clear is dropped.
- R8: A byte offered while `ecc_en` is low is ignored. It changes no parity and does not advance the byte count, even when it would otherwise have been the last byte of a chunk.
- R9: Between chunk completions and clears, `code_raw` holds its value.
- R10: Each chunk's code depends only on that chunk's bytes. Back-to-back chunks with no idle cycle between them get independent codes.
- R11: `code_from_read` takes the value of `rd_dir` on the edge that completes a chunk, and holds it until the next completion or clear.
- R12: Flipping data bit b of byte a changes the code by a fixed mask. For every k, the mask sets bit 8+2k+a[k]. For every i, it sets bit 2+2i+b[i]. This is what lets the reader locate a single bad bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Accumulation enable |
| ecc_clr | input | 1 | Clear strobe for accumulator, counter and code register |
| rd_dir | input | 1 | Transfer direction, 1 = read from flash |
| byte_valid | input | 1 | A data byte is present this cycle |
| byte_data | input | 8 | Data byte |
| code_raw | output | 24 | Latched Hamming code of the last completed chunk |
| code_valid | output | 1 | One-cycle pulse when a new code is latched |
| code_from_read | output | 1 | Direction flag stored with the latched code |
| spare_bytes | output | 24 | Spare-area form of the code, first byte in bits 23:16 |

## Verification
On every cycle, the assertions check the following: the valid pulse lasts one cycle and follows the completing byte; a clear empties the register; the code holds between events; disabled cycles leave the byte count alone; the accumulator is empty whenever the count is back at zero; and every even/odd pair of a latched code agrees on the chunk parity. The actual parity values can only be shown by the bench scenarios. These are the bit-exact line and column values for several data patterns, the spare-byte inversion and order, the effect of enable gaps and mid-chunk clears on which bytes count, and the exact code difference caused by one flipped bit.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
    localparam int BYTE_W      = 8;
    localparam int CHUNK_BYTES = 256;
    localparam int ADDR_W      = $clog2(CHUNK_BYTES);
    localparam int GRP_N       = $clog2(BYTE_W);
    localparam int LINE_W      = 2 * ADDR_W;
    localparam int COL_W       = 2 * GRP_N;
    localparam int PAD_W       = 2;
    localparam int CODE_W      = LINE_W + COL_W + PAD_W;

    typedef logic [ADDR_W-1:0] chunk_addr_t;
    typedef logic [BYTE_W-1:0] data_byte_t;
    typedef logic [CODE_W-1:0] ecc_code_t;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [COL_W-1:0]  col;
    } parity_acc_t;

    // Column parity contribution of one byte: odd slot for positions with group bit set.
    function automatic logic [COL_W-1:0] col_step(data_byte_t d);
        logic [COL_W-1:0] r;
        r = '0;
        for (int i = 0; i < GRP_N; i++) begin
            for (int j = 0; j < BYTE_W; j++) begin
                if (((j >> i) & 1) != 0) r[2*i+1] = r[2*i+1] ^ d[j];
                else                     r[2*i]   = r[2*i]   ^ d[j];
            end
        end
        return r;
    endfunction

    // Line parity contribution: byte parity lands in odd or even slot per address bit.
    function automatic logic [LINE_W-1:0] line_step(chunk_addr_t a, logic p);
        logic [LINE_W-1:0] r;
        r = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            if (a[k]) r[2*k+1] = p;
            else      r[2*k]   = p;
        end
        return r;
    endfunction

    function automatic ecc_code_t pack_code(parity_acc_t s);
        return {s.line, s.col, {PAD_W{1'b0}}};
    endfunction

    function automatic ecc_code_t spare_form(ecc_code_t c);
        ecc_code_t s;
        s = c << PAD_W;
        return ~s;
    endfunction
endpackage

// File: rtl/ecc_byte_counter.sv
module ecc_byte_counter
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        take,
    output chunk_addr_t addr,
    output logic        last
);
    assign last = take && (addr == chunk_addr_t'(CHUNK_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr)  addr <= '0;
        else if (take)   addr <= addr + 1'b1;
    end

    // R2: an accepted byte moves the count forward by exactly one (with wrap)
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (take && !clr) |=> (addr == chunk_addr_t'($past(addr) + 1'b1)));
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import nand_ecc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        take,
    input  logic        last,
    input  chunk_addr_t addr,
    input  data_byte_t  data,
    output parity_acc_t acc,
    output parity_acc_t acc_final
);
    always_comb begin
        acc_final = acc;
        if (take) begin
            acc_final.line = acc.line ^ line_step(addr, ^data);
            acc_final.col  = acc.col  ^ col_step(data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  acc <= '0;
        else if (last)   acc <= '0;
        else if (take)   acc <= acc_final;
    end

    // R10: after a chunk closes the accumulator starts empty
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        last |=> (acc == '0));
endmodule

// File: rtl/ecc_code_format.sv
module ecc_code_format
    import nand_ecc_pkg::*;
(
    input  ecc_code_t code,
    output ecc_code_t spare
);
    localparam int NBYTES = CODE_W / 8;
    ecc_code_t inv;
    assign inv = spare_form(code);

    // First spare byte is the most significant byte of the word
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign spare[CODE_W-1-8*g -: 8] = inv[CODE_W-1-8*g -: 8];
    end
endmodule

// File: rtl/nand_chunk_ecc_gen.sv
module nand_chunk_ecc_gen
    import nand_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic              ecc_clr,
    input  logic              rd_dir,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [CODE_W-1:0] code_raw,
    output logic              code_valid,
    output logic              code_from_read,
    output logic [CODE_W-1:0] spare_bytes
);
    logic        take;
    logic        last;
    chunk_addr_t addr;
    parity_acc_t acc;
    parity_acc_t acc_final;
    ecc_code_t   spare_w;

    assign take = ecc_en && byte_valid && !ecc_clr;

    ecc_byte_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (ecc_clr),
        .take (take),
        .addr (addr),
        .last (last)
    );

    ecc_parity_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (ecc_clr),
        .take      (take),
        .last      (last),
        .addr      (addr),
        .data      (byte_data),
        .acc       (acc),
        .acc_final (acc_final)
    );

    always_ff @(posedge clk) begin
        if (rst || ecc_clr) begin
            code_raw       <= '0;
            code_valid     <= 1'b0;
            code_from_read <= 1'b0;
        end else if (last) begin
            code_raw       <= pack_code(acc_final);
            code_valid     <= 1'b1;
            code_from_read <= rd_dir;
        end else begin
            code_valid     <= 1'b0;
        end
    end

    ecc_code_format u_fmt (
        .code  (code_raw),
        .spare (spare_w)
    );
    assign spare_bytes = spare_w;

    // Every even/odd pair of a finished code must agree on the chunk parity
    logic pairs_ok;
    always_comb begin
        logic tot;
        tot = code_raw[PAD_W] ^ code_raw[PAD_W+1];
        pairs_ok = 1'b1;
        for (int p = PAD_W; p < CODE_W; p += 2) begin
            if ((code_raw[p] ^ code_raw[p+1]) != tot) pairs_ok = 1'b0;
        end
    end

    p_pair_parity_r4: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> (pairs_ok && code_raw[PAD_W-1:0] == '0));
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        code_valid |=> !code_valid);
    p_valid_follows_last_r2: assert property (@(posedge clk) disable iff (rst)
        last |=> code_valid);
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
        ecc_clr |=> (code_raw == '0 && !code_valid && addr == '0));
    p_hold_code_r9: assert property (@(posedge clk) disable iff (rst)
        (!last && !ecc_clr) |=> $stable(code_raw));
    p_disabled_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!ecc_en && !ecc_clr) |=> ($stable(addr) && $stable(acc) && !code_valid));
    p_empty_at_start_r10: assert property (@(posedge clk) disable iff (rst)
        (addr == '0) |-> (acc == '0));
endmodule

// File: tb/tb_nand_chunk_ecc_gen.sv
module tb_nand_chunk_ecc_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        ecc_en, ecc_clr, rd_dir, byte_valid;
    logic [7:0]  byte_data;
    logic [23:0] code_raw, spare_bytes;
    logic        code_valid, code_from_read;

    always #4 clk = ~clk;

    nand_chunk_ecc_gen dut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .ecc_clr(ecc_clr), .rd_dir(rd_dir),
        .byte_valid(byte_valid), .byte_data(byte_data), .code_raw(code_raw),
        .code_valid(code_valid), .code_from_read(code_from_read), .spare_bytes(spare_bytes)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] buf_a [256];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Code change from a single set bit at byte a, position b (R12 rule)
    function automatic logic [23:0] bit_mask(int a, int b);
        logic [23:0] r = '0;
        for (int k = 0; k < 8; k++) r[8 + 2*k + ((a >> k) & 1)] = 1'b1;
        for (int i = 0; i < 3; i++) r[2 + 2*i + ((b >> i) & 1)] = 1'b1;
        return r;
    endfunction

    function automatic logic [23:0] model_code();
        logic [23:0] r = '0;
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 8; b++)
                if (buf_a[a][b]) r = r ^ bit_mask(a, b);
        return r;
    endfunction

    function automatic logic [23:0] model_spare(logic [23:0] c);
        return ~{c[21:0], 2'b00};
    endfunction

    task automatic fill(int kind, int seed);
        int x = seed;
        for (int a = 0; a < 256; a++) begin
            x = x * 1103515245 + 12345;
            case (kind)
                0: buf_a[a] = 8'h00;
                1: buf_a[a] = 8'(a);
                2: buf_a[a] = 8'hA5;
                3: buf_a[a] = 8'(x >>> 16);
                default: buf_a[a] = (a == 8'h37) ? 8'h20 : 8'h00;
            endcase
        end
    endtask

    task automatic send_byte(logic [7:0] d);
        byte_valid = 1'b1;
        byte_data  = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic send_range(int lo, int hi);
        for (int a = lo; a < hi; a++) send_byte(buf_a[a]);
    endtask

    task automatic t_reset();
        chk("R1 code", {8'h0, code_raw}, 32'h0);
        chk("R1 valid", {31'h0, code_valid}, 32'h0);
        chk("R1 dir", {31'h0, code_from_read}, 32'h0);
        chk("R1 spare", {8'h0, spare_bytes}, 32'h00FFFFFF);
    endtask

    task automatic t_pattern(int kind, int seed, logic dir);
        logic [23:0] exp;
        fill(kind, seed);
        rd_dir = dir;
        send_range(0, 256);
        exp = model_code();
        chk("R2 valid after last byte", {31'h0, code_valid}, 32'h1);
        chk("R3 line parity", {16'h0, code_raw[23:8]}, {16'h0, exp[23:8]});
        chk("R4 column parity", {26'h0, code_raw[7:2]}, {26'h0, exp[7:2]});
        chk("R5 pad bits", {30'h0, code_raw[1:0]}, 32'h0);
        chk("R6 spare bytes", {8'h0, spare_bytes}, {8'h0, model_spare(exp)});
        chk("R11 direction", {31'h0, code_from_read}, {31'h0, dir});
        rd_dir = ~dir;
        @(negedge clk);
        chk("R2 single pulse", {31'h0, code_valid}, 32'h0);
        chk("R9 hold", {8'h0, code_raw}, {8'h0, exp});
        chk("R11 dir held", {31'h0, code_from_read}, {31'h0, dir});
    endtask

    task automatic t_idle();
        logic [23:0] c0 = code_raw;
        bit bad = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (code_valid || code_raw !== c0) bad = 1;
        end
        chk("R9 idle hold", {31'h0, bad}, 32'h0);
    endtask

    task automatic t_enable_gap();
        bit saw = 0;
        fill(3, 77);
        send_range(0, 255);
        ecc_en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            send_byte(8'hFF);
            if (code_valid) saw = 1;
        end
        chk("R8 no completion while disabled", {31'h0, saw}, 32'h0);
        ecc_en = 1'b1;
        send_range(255, 256);
        chk("R8 completes on enabled byte", {31'h0, code_valid}, 32'h1);
        chk("R8 ignored bytes", {8'h0, code_raw}, {8'h0, model_code()});
    endtask

    task automatic t_clear();
        fill(3, 5);
        send_range(0, 100);
        ecc_clr = 1'b1;
        @(negedge clk);
        ecc_clr = 1'b0;
        chk("R7 code zero", {8'h0, code_raw}, 32'h0);
        chk("R7 spare after clear", {8'h0, spare_bytes}, 32'h00FFFFFF);
        // clear together with a byte: byte dropped
        ecc_clr = 1'b1;
        send_byte(8'hFF);
        ecc_clr = 1'b0;
        fill(3, 9);
        send_range(0, 256);
        chk("R7 restart valid", {31'h0, code_valid}, 32'h1);
        chk("R7 restart code", {8'h0, code_raw}, {8'h0, model_code()});
    endtask

    task automatic t_back_to_back();
        fill(3, 21);
        send_range(0, 256);
        chk("R10 first chunk", {8'h0, code_raw}, {8'h0, model_code()});
        fill(1, 0);
        for (int a = 0; a < 256; a++) buf_a[a] = ~buf_a[a];
        send_range(0, 256);
        chk("R10 second chunk", {8'h0, code_raw}, {8'h0, model_code()});
    endtask

    task automatic t_flip();
        logic [23:0] c0;
        fill(3, 1234);
        send_range(0, 256);
        c0 = code_raw;
        buf_a[8'hC3][6] = ~buf_a[8'hC3][6];
        send_range(0, 256);
        // byte 0xC3 bit 6: line bits 23,21,18,16,14,12,11,9; column bits 7,5,2
        chk("R12 flip mask", {8'h0, c0 ^ code_raw}, 32'h00A55AA4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ecc_en = 1'b1; ecc_clr = 1'b0; rd_dir = 1'b0;
        byte_valid = 1'b0; byte_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pattern(0, 0, 1'b1);
        t_pattern(1, 0, 1'b0);
        t_pattern(2, 0, 1'b1);
        t_pattern(3, 42, 1'b0);
        t_pattern(4, 0, 1'b1);
        t_idle();
        t_enable_gap();
        t_clear();
        t_back_to_back();
        t_flip();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule